// File: doc/BRIEF.md
# I2C Controller Register Front End

This block sits between a simple strobe-qualified register bus and a byte-level I2C protocol engine. It keeps six word-indexed registers: configuration, status, command, target address, receive data and transmit data. A 3-bit word index selects the register. Software queues bytes for transmission by writing the transmit-data register and drains received bytes by reading the receive-data register. Each side is backed by an eight-entry FIFO. The engine-facing side of each FIFO is a plain pop or push strobe.

A command write hands a combined operation to the engine as a one-cycle launch pulse. The operation can mix start, stop, read, write and NACK. The front end also keeps three sticky event flags reported by the engine: byte done, missing acknowledge and lost arbitration. It drives an interrupt for as long as any of them is set. The engine itself is not part of this block.

Top module: `i2cm_regbank`

## Requirements
- R1: After reset, configuration reads 0, the interrupt is low, no launch pulse is issued, and status reads 0x14 (both FIFOs empty, nothing else set).
- R2: The configuration register is at word index 0. It holds the clock divider in bits [31:16], stretch enable in bit 3 and auto-acknowledge enable in bit 2. Every other bit reads 0. Each byte lane is written only when its byte-select bit is 1. The stored fields drive the cfg outputs directly.
- R3: A write to word index 5 with byte-select bit 0 set pushes data bits [7:0] into the transmit FIFO. The engine receives the bytes in order on eng_tx_data_o and removes each one with eng_tx_pop_i. A push while the FIFO holds 8 bytes is dropped.
- R4: A read of word index 4 returns the oldest received byte in bits [7:0] (upper bits 0) and removes it. A read while the receive FIFO is empty returns 0 and removes nothing. An engine push while the FIFO holds 8 bytes is dropped.
- R5: A write to word index 2 with byte-select bit 0 set and eng_busy_i low is accepted. In the cycle after the write, eng_go_o is high for exactly one cycle. At the same time eng_op_o shows {start=bit7, stop=bit6, read=bit5, write=bit4, nack=bit3} of the written byte, packed from eng_op_o[4] down to [0]. The command register reads back the last accepted bits [7:3].
- R6: A command write while eng_busy_i is high produces no launch pulse and leaves the sticky flags unchanged.
- R7: Engine pulses set sticky status bits: eng_done_i sets bit 0, eng_ackerr_i sets bit 5 and eng_arblost_i sets bit 6. Each bit is visible from the cycle after its pulse and stays set until cleared. A set in the same cycle as a clear wins.
- R8: A write to status (word index 1) with byte-select bit 0 set clears each sticky bit that is written as 1. Sticky bits written as 0 are left alone.
- R9: An accepted command write clears all three sticky bits.
- R10: irq_o is high exactly while at least one sticky bit is set.
- R11: Status bit 7 follows eng_busy_i. Bit 4 is transmit-empty, bit 3 transmit-full, bit 2 receive-empty and bit 1 receive-full. eng_tx_empty_o and eng_rx_full_o show the same FIFO conditions.
- R12: The target-address register at word index 3 stores data bits [7:0] when byte-select bit 0 is set. It drives eng_addr_o and reads back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_stb_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Word index of the register |
| bus_bsel_i | input | 4 | Byte-lane enables for writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while a read is strobed |
| cfg_div_o | output | 16 | Clock divider setting |
| cfg_stretch_o | output | 1 | Clock-stretch enable |
| cfg_autoack_o | output | 1 | Auto-acknowledge enable |
| eng_addr_o | output | 8 | Target address byte |
| eng_go_o | output | 1 | One-cycle launch of an operation |
| eng_op_o | output | 5 | {start, stop, read, write, nack} |
| eng_busy_i | input | 1 | Engine transfer in progress |
| eng_tx_pop_i | input | 1 | Engine takes the head transmit byte |
| eng_tx_data_o | output | 8 | Head transmit byte |
| eng_tx_empty_o | output | 1 | Transmit FIFO empty |
| eng_rx_push_i | input | 1 | Engine delivers a received byte |
| eng_rx_data_i | input | 8 | Received byte |
| eng_rx_full_o | output | 1 | Receive FIFO full |
| eng_done_i | input | 1 | Byte finished event |
| eng_ackerr_i | input | 1 | Missing acknowledge event |
| eng_arblost_i | input | 1 | Arbitration lost event |
| irq_o | output | 1 | Interrupt, high while any sticky flag is set |

## Verification
A FIFO pointer or count that goes wrong shows up at the ports in one of three ways: the wrong byte on the next receive-data read, the wrong head byte at eng_tx_data_o, or a full/empty status bit that is off one access after the ninth push or after an empty read. A sticky flag that is lost or wrongly cleared shows in irq_o and status in the very next cycle. A bad command decode shows in eng_op_o, or as a missing or doubled launch pulse, one cycle after the write. Each of these is visible within a single bus access of the cause, so directed sequences that read status right after every event pin the fault down.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam int BUS_W   = 32;
  localparam int LANES   = BUS_W / 8;
  localparam int BYTE_W  = 8;
  localparam int N_FLAGS = 3;

  typedef enum logic [2:0] {
    RA_CFG  = 3'd0,
    RA_STAT = 3'd1,
    RA_CMD  = 3'd2,
    RA_TGT  = 3'd3,
    RA_RXD  = 3'd4,
    RA_TXD  = 3'd5
  } reg_idx_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rd;
    logic wr;
    logic nack;
  } eng_op_t;

  // Byte-lane merge of a bus write into a stored word
  function automatic logic [BUS_W-1:0] merge_bytes(input logic [BUS_W-1:0] cur,
                                                   input logic [BUS_W-1:0] nxt,
                                                   input logic [LANES-1:0] sel);
    logic [BUS_W-1:0] r;
    r = cur;
    for (int b = 0; b < LANES; b++)
      if (sel[b]) r[b*8 +: 8] = nxt[b*8 +: 8];
    return r;
  endfunction

  // Command byte to engine operation
  function automatic eng_op_t decode_cmd(input logic [7:0] c);
    eng_op_t o;
    o.start = c[7];
    o.stop  = c[6];
    o.rd    = c[5];
    o.wr    = c[4];
    o.nack  = c[3];
    return o;
  endfunction

  // Status word; flags = {arb, ackerr, done}
  function automatic logic [7:0] pack_status(input logic busy,
                                             input logic [N_FLAGS-1:0] flags,
                                             input logic txe, input logic txf,
                                             input logic rxe, input logic rxf);
    return {busy, flags[2], flags[1], txe, txf, rxe, rxf, flags[0]};
  endfunction

endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign full_o  = (count == CW'(DEPTH));
  assign empty_o = (count == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = empty_o ? '0 : mem[rd_ptr];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i)
    if (push_ok) mem[wr_ptr] <= data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/i2cm_sticky.sv
module i2cm_sticky #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          flags_o[i] <= 1'b0;
      else if (set_i[i])    flags_o[i] <= 1'b1;
      else if (clr_i[i])    flags_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cm_regbank.sv
module i2cm_regbank
  import i2cm_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_stb_i,
  input  logic        bus_we_i,
  input  logic [2:0]  bus_addr_i,
  input  logic [3:0]  bus_bsel_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic [15:0] cfg_div_o,
  output logic        cfg_stretch_o,
  output logic        cfg_autoack_o,
  output logic [7:0]  eng_addr_o,
  output logic        eng_go_o,
  output logic [4:0]  eng_op_o,
  input  logic        eng_busy_i,
  input  logic        eng_tx_pop_i,
  output logic [7:0]  eng_tx_data_o,
  output logic        eng_tx_empty_o,
  input  logic        eng_rx_push_i,
  input  logic [7:0]  eng_rx_data_i,
  output logic        eng_rx_full_o,
  input  logic        eng_done_i,
  input  logic        eng_ackerr_i,
  input  logic        eng_arblost_i,
  output logic        irq_o
);
  localparam int          DIV_LSB  = BUS_W - DIV_W;
  localparam logic [31:0] CFG_MASK = {{DIV_W{1'b1}}, {(DIV_LSB-4){1'b0}}, 4'b1100};

  // Named bus events
  logic wr_ev, rd_ev;
  logic wr_cfg, wr_stat, wr_cmd, wr_tgt, wr_txd, rd_rxd;
  logic cmd_accept;

  assign wr_ev   = bus_stb_i && bus_we_i;
  assign rd_ev   = bus_stb_i && !bus_we_i;
  assign wr_cfg  = wr_ev && (bus_addr_i == RA_CFG);
  assign wr_stat = wr_ev && (bus_addr_i == RA_STAT) && bus_bsel_i[0];
  assign wr_cmd  = wr_ev && (bus_addr_i == RA_CMD)  && bus_bsel_i[0];
  assign wr_tgt  = wr_ev && (bus_addr_i == RA_TGT)  && bus_bsel_i[0];
  assign wr_txd  = wr_ev && (bus_addr_i == RA_TXD)  && bus_bsel_i[0];
  assign rd_rxd  = rd_ev && (bus_addr_i == RA_RXD);
  assign cmd_accept = wr_cmd && !eng_busy_i;

  // Stored registers
  logic [31:0] cfg_q;
  logic [7:0]  tgt_q;
  logic [4:0]  cmd_q;
  logic        go_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      tgt_q <= '0;
      cmd_q <= '0;
      go_q  <= 1'b0;
    end else begin
      go_q <= cmd_accept;
      if (wr_cfg)     cfg_q <= merge_bytes(cfg_q, bus_wdata_i, bus_bsel_i) & CFG_MASK;
      if (wr_tgt)     tgt_q <= bus_wdata_i[7:0];
      if (cmd_accept) cmd_q <= decode_cmd(bus_wdata_i[7:0]);
    end
  end

  assign cfg_div_o     = cfg_q[BUS_W-1 -: DIV_W];
  assign cfg_stretch_o = cfg_q[3];
  assign cfg_autoack_o = cfg_q[2];
  assign eng_addr_o    = tgt_q;
  assign eng_go_o      = go_q;
  assign eng_op_o      = cmd_q;

  // FIFOs
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [7:0] rx_head;

  i2cm_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .push_i (wr_txd), .data_i (bus_wdata_i[7:0]),
    .pop_i  (eng_tx_pop_i), .head_o (eng_tx_data_o),
    .full_o (tx_full), .empty_o (tx_empty)
  );

  i2cm_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .push_i (eng_rx_push_i), .data_i (eng_rx_data_i),
    .pop_i  (rd_rxd), .head_o (rx_head),
    .full_o (rx_full), .empty_o (rx_empty)
  );

  assign eng_tx_empty_o = tx_empty;
  assign eng_rx_full_o  = rx_full;

  // Sticky flags {arb, ackerr, done}
  logic [N_FLAGS-1:0] sticky_q, sticky_set, sticky_clr;

  assign sticky_set = {eng_arblost_i, eng_ackerr_i, eng_done_i};
  assign sticky_clr = cmd_accept ? '1
                    : wr_stat    ? {bus_wdata_i[6], bus_wdata_i[5], bus_wdata_i[0]}
                    : '0;

  i2cm_sticky #(.N(N_FLAGS)) u_flags (
    .clk_i, .rst_ni,
    .set_i (sticky_set), .clr_i (sticky_clr), .flags_o (sticky_q)
  );

  assign irq_o = |sticky_q;

  // Read mux
  always_comb begin
    bus_rdata_o = '0;
    if (rd_ev) begin
      unique case (bus_addr_i)
        RA_CFG:  bus_rdata_o = cfg_q;
        RA_STAT: bus_rdata_o = {24'b0, pack_status(eng_busy_i, sticky_q,
                                                   tx_empty, tx_full, rx_empty, rx_full)};
        RA_CMD:  bus_rdata_o = {24'b0, cmd_q, 3'b000};
        RA_TGT:  bus_rdata_o = {24'b0, tgt_q};
        RA_RXD:  bus_rdata_o = {24'b0, rx_head};
        default: bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/i2cm_regbank_chk.sv
module i2cm_regbank_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_stb_i,
  input logic        bus_we_i,
  input logic [2:0]  bus_addr_i,
  input logic [3:0]  bus_bsel_i,
  input logic [31:0] bus_rdata_o,
  input logic        eng_busy_i,
  input logic        eng_go_o,
  input logic        eng_done_i,
  input logic        eng_ackerr_i,
  input logic        eng_arblost_i,
  input logic        irq_o,
  input logic [2:0]  sticky_q,
  input logic [2:0]  sticky_clr,
  input logic        rx_empty
);
  // R5
  go_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_go_o |=> !eng_go_o);

  // R6
  go_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_go_o |-> $past(bus_stb_i && bus_we_i && bus_addr_i == 3'd2
                       && bus_bsel_i[0] && !eng_busy_i));

  // R7
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(sticky_q) & ~$past(sticky_clr) & ~sticky_q) == 3'b000));

  // R10
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(eng_done_i || eng_ackerr_i || eng_arblost_i));

  // R4
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_stb_i && !bus_we_i && bus_addr_i == 3'd4 && rx_empty) |-> (bus_rdata_o == 32'd0));
endmodule

bind i2cm_regbank i2cm_regbank_chk u_chk (
  .clk_i, .rst_ni, .bus_stb_i, .bus_we_i, .bus_addr_i, .bus_bsel_i, .bus_rdata_o,
  .eng_busy_i, .eng_go_o, .eng_done_i, .eng_ackerr_i, .eng_arblost_i, .irq_o,
  .sticky_q (sticky_q), .sticky_clr (sticky_clr), .rx_empty (rx_empty)
);

// File: tb/i2cm_regbank_tb.sv
module i2cm_regbank_tb;
  logic        clk = 0, rst_n = 0;
  logic        stb = 0, we = 0;
  logic [2:0]  addr = 0;
  logic [3:0]  bsel = 0;
  logic [31:0] wdata = 0, rdata;
  logic [15:0] div;
  logic        stretch, autoack, go, tx_empty, rx_full, irq;
  logic [7:0]  tgt, tx_data;
  logic [4:0]  op;
  logic        busy = 0, tx_pop = 0, rx_push = 0, ev_done = 0, ev_ack = 0, ev_arb = 0;
  logic [7:0]  rx_data = 0;
  int          checks = 0, errors = 0;

  always #4 clk = ~clk;

  i2cm_regbank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_stb_i(stb), .bus_we_i(we), .bus_addr_i(addr),
    .bus_bsel_i(bsel), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .cfg_div_o(div), .cfg_stretch_o(stretch), .cfg_autoack_o(autoack),
    .eng_addr_o(tgt), .eng_go_o(go), .eng_op_o(op), .eng_busy_i(busy),
    .eng_tx_pop_i(tx_pop), .eng_tx_data_o(tx_data), .eng_tx_empty_o(tx_empty),
    .eng_rx_push_i(rx_push), .eng_rx_data_i(rx_data), .eng_rx_full_o(rx_full),
    .eng_done_i(ev_done), .eng_ackerr_i(ev_ack), .eng_arblost_i(ev_arb), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk); stb = 1; we = 1; addr = a; wdata = d; bsel = s;
    @(posedge clk); #1 stb = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); stb = 1; we = 0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 stb = 0;
  endtask

  task automatic eng_push(input logic [7:0] b);
    @(negedge clk); rx_push = 1; rx_data = b;
    @(posedge clk); #1 rx_push = 0;
  endtask

  task automatic pulse_ev(input int which);
    @(negedge clk);
    if (which == 0) ev_done = 1; else if (which == 1) ev_ack = 1; else ev_arb = 1;
    @(posedge clk); #1 ev_done = 0; ev_ack = 0; ev_arb = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(3'd1, d); check("R1 status", d, 32'h14);
    bus_rd(3'd0, d); check("R1 cfg", d, 0);
    check("R1 irq", irq, 0);
    check("R1 go", go, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    bus_wr(3'd0, 32'h007C_FFFF, 4'hF);
    bus_rd(3'd0, d); check("R2 masked write", d, 32'h007C_000C);
    check("R2 outputs", {div, stretch, autoack}, {16'h007C, 2'b11});
    bus_wr(3'd0, 32'hFFFF_FFF3, 4'b0100);
    bus_rd(3'd0, d); check("R2 lane2 only", d, 32'h00FF_000C);
    bus_wr(3'd0, 32'h0, 4'b0001);
    bus_rd(3'd0, d); check("R2 lane0 only", d, 32'h00FF_0000);
    check("R2 cfg bits", {stretch, autoack}, 2'b00);
  endtask

  task automatic t_tgt();
    logic [31:0] d;
    bus_wr(3'd3, 32'hA5, 4'h1);
    check("R12 eng_addr", tgt, 8'hA5);
    bus_wr(3'd3, 32'h0000_FF00, 4'h2);
    bus_rd(3'd3, d); check("R12 readback", d, 32'hA5);
  endtask

  task automatic t_tx();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) bus_wr(3'd5, 32'h10 + i, 4'h1);
    bus_rd(3'd1, d); check("R11 tx full flags", d[4:3], 2'b01);
    bus_wr(3'd5, 32'hEE, 4'h1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R3 tx order", tx_data, 8'h10 + i);
      tx_pop = 1; @(posedge clk); #1 tx_pop = 0;
    end
    check("R3 overflow dropped", tx_empty, 1);
    bus_rd(3'd1, d); check("R11 tx empty flags", d[4:3], 2'b10);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    bus_rd(3'd4, d); check("R4 empty read", d, 0);
    for (int i = 0; i < 8; i++) eng_push(8'h80 + i);
    check("R11 rx_full out", rx_full, 1);
    bus_rd(3'd1, d); check("R11 rx flags", d[2:1], 2'b01);
    eng_push(8'hFF);
    for (int i = 0; i < 8; i++) begin
      bus_rd(3'd4, d); check("R4 rx order", d, 32'h80 + i);
    end
    bus_rd(3'd4, d); check("R4 drained empty read", d, 0);
    eng_push(8'h3C);
    bus_rd(3'd4, d); check("R4 no pointer move", d, 32'h3C);
  endtask

  task automatic t_cmd();
    logic [31:0] d;
    bus_wr(3'd2, 32'hD0, 4'h1);
    check("R5 go", go, 1);
    check("R5 op", op, 5'b11010);
    @(posedge clk); #1 check("R5 go one cycle", go, 0);
    bus_rd(3'd2, d); check("R5 readback", d, 32'hD0);
    bus_wr(3'd2, 32'h68, 4'h1);
    check("R5 op2", {go, op}, {1'b1, 5'b01101});
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse_ev(0);
    check("R10 irq on done", irq, 1);
    repeat (3) @(posedge clk);
    #1 bus_rd(3'd1, d); check("R7 done held", d[0], 1);
    pulse_ev(1);
    pulse_ev(2);
    bus_rd(3'd1, d); check("R7 all flags", {d[6], d[5], d[0]}, 3'b111);
    bus_wr(3'd1, 32'h01, 4'h1);
    bus_rd(3'd1, d); check("R8 w1c done", {d[6], d[5], d[0]}, 3'b110);
    bus_wr(3'd1, 32'h60, 4'h2);
    bus_rd(3'd1, d); check("R8 lane gated", {d[6], d[5]}, 2'b11);
    bus_wr(3'd1, 32'h60, 4'h1);
    check("R10 irq cleared", irq, 0);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    pulse_ev(1);
    busy = 1;
    bus_rd(3'd1, d); check("R11 busy bit", d[7], 1);
    bus_wr(3'd2, 32'h90, 4'h1);
    check("R6 no go", go, 0);
    @(posedge clk); #1 check("R6 still no go", go, 0);
    bus_rd(3'd1, d); check("R6 flag kept", d[5], 1);
    busy = 0;
    bus_wr(3'd2, 32'h90, 4'h1);
    check("R9 go after idle", go, 1);
    check("R9 flags cleared irq", irq, 0);
    bus_rd(3'd2, d); check("R6 op from accepted", d, 32'h90);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_cfg();
    t_tgt();
    t_tx();
    t_rx();
    t_cmd();
    t_sticky();
    t_busy();
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule